// File: doc/BRIEF.md
# Serial Servo Command Receiver

This block takes servo commands from a control processor over a serial link. The link has four wires: a framing strobe, a data line, a serial clock and an active-low select. All four are brought into the system clock domain through a synchronizer. The processor raises the strobe, shifts in one or two bytes MSB first on rising serial-clock edges, and then lowers the strobe. The falling strobe is the moment the command runs. Until then nothing the processor sends has any effect.

A frame is decoded only when its bit count matches the length of its opcode: eight bits for single-byte opcodes, sixteen for the track-count opcode. Frames that fail this test, frames with an unknown opcode and frames that end while the select is high are dropped. An executed command updates the control registers it targets and raises a one-cycle valid pulse that carries the opcode and the operand.

Two opcodes switch a deglitch filter on the serial clock on and off. While the filter is on, a change of clock level counts only after it has held for a set number of system clocks. Reset turns the filter off.

The control flow is a three-state machine:
- `ST_IDLE`: waits for a strobe rise. On the rise (transition *open*) it clears the bit counter and moves to `ST_RECV`.
- `ST_RECV`: shifts in bits. On a strobe fall (transition *close*) it moves to `ST_EXEC`.
- `ST_EXEC`: decodes and applies the command for one cycle, then returns to `ST_IDLE` (transition *done*).

Top module: `svc_cmd_rx`

## Requirements
- R1: While the machine is collecting bits, the select is low and the strobe is high, each rising serial-clock edge shifts `sdata` in. Bits are taken MSB first, so the first bit of a byte is bit 7 of that byte.
- R2: A command runs only on a falling strobe edge. Its register updates and the valid pulse appear on the fourth rising system-clock edge after the strobe low level is set up before an edge (SYNC_STAGES + 2).
- R3: The single-byte control opcodes are:
  - 0x10 clears `focus_on` and 0x11 sets it.
  - 0x30 clears `motor_run` and 0x31 sets it.
  - 0x40 clears `mute_on` and 0x41 sets it.
  - 0x50 to 0x53 load `gp_out` with opcode bits 1:0.
- R4: Opcodes 0x20 to 0x26 load `jump_tracks` with 1, 2, 4, 16, 32, 64 or 128, selected by opcode bits 2:0 in that order.
- R5: Opcode 0x60 followed by a second byte is a two-byte command. The second byte is loaded into `track_count` and reported on `cmd_operand`.
- R6: A frame is discarded, with no valid pulse and no register change, in any of these cases:
  - its bit count is not 8 for a single-byte opcode;
  - its bit count is not 16 for opcode 0x60;
  - its opcode is unknown (including 0x27);
  - the select is high when the strobe falls.
- R7: Serial-clock edges that occur while the select is high are ignored and do not count as bits.
- R8: Opcode 0xEF sets `deglitch_on` and 0xEE clears it. A low `rst_n` clears it.
- R9: With the filter on, a serial-clock level must hold for FILT_LEN (3) system clocks before it counts, so a one-clock pulse adds no bit. With the filter off, a one-clock pulse adds a bit.
- R10: Each executed command gives `cmd_valid` high for exactly one cycle, with `cmd_opcode` and `cmd_operand`. The operand is 0 for single-byte commands.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| strobe | input | 1 | Framing strobe; a command runs on its fall |
| sdata | input | 1 | Serial data, MSB first |
| sclk | input | 1 | Serial clock; data taken on rising edges |
| cmd_valid | output | 1 | One-cycle pulse per executed command |
| cmd_opcode | output | 8 | Opcode of the executed command |
| cmd_operand | output | 8 | Second byte, or 0 |
| focus_on | output | 1 | Focus start request |
| jump_tracks | output | 8 | Selected track-jump span |
| motor_run | output | 1 | Disc motor run |
| mute_on | output | 1 | Muting |
| track_count | output | 8 | Track count operand |
| gp_out | output | 2 | General-purpose outputs |
| deglitch_on | output | 1 | Serial-clock deglitch enabled |

## Verification
The hardest case to reach from the ports is a one-system-clock pulse on the serial clock that lands inside a frame while the deglitch mode is in a known state. Its effect shows only indirectly, as an extra bit that spoils the length check. The stimulus first sets the mode with the 0xEF and 0xEE commands or with reset, then sends a frame with such a pulse inserted between two bits. The pulse must drop a frame while the filter is off and must leave the frame intact while it is on. A frame in which the select rises for its second byte reaches the ignored-bit case in the same way, since the frame then runs as a single-byte command.

// File: rtl/svc_pkg.sv
package svc_pkg;
    localparam int unsigned CMD_W = 8;

    typedef logic [CMD_W-1:0] cmd_byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_EXEC = 2'd2
    } rx_state_t;

    localparam cmd_byte_t OP_FOCUS_OFF  = 8'h10;
    localparam cmd_byte_t OP_FOCUS_ON   = 8'h11;
    localparam cmd_byte_t OP_JUMP_BASE  = 8'h20;
    localparam cmd_byte_t OP_JUMP_LAST  = 8'h26;
    localparam cmd_byte_t OP_MOTOR_STOP = 8'h30;
    localparam cmd_byte_t OP_MOTOR_RUN  = 8'h31;
    localparam cmd_byte_t OP_MUTE_OFF   = 8'h40;
    localparam cmd_byte_t OP_MUTE_ON    = 8'h41;
    localparam cmd_byte_t OP_GP_BASE    = 8'h50;
    localparam cmd_byte_t OP_GP_LAST    = 8'h53;
    localparam cmd_byte_t OP_TCOUNT     = 8'h60;
    localparam cmd_byte_t OP_NX_OFF     = 8'hEE;
    localparam cmd_byte_t OP_NX_ON      = 8'hEF;

    // Single-byte opcodes understood by the receiver.
    function automatic logic is_one_byte(input cmd_byte_t op);
        is_one_byte = (op == OP_FOCUS_OFF) || (op == OP_FOCUS_ON) ||
                      ((op >= OP_JUMP_BASE) && (op <= OP_JUMP_LAST)) ||
                      (op == OP_MOTOR_STOP) || (op == OP_MOTOR_RUN) ||
                      (op == OP_MUTE_OFF) || (op == OP_MUTE_ON) ||
                      ((op >= OP_GP_BASE) && (op <= OP_GP_LAST)) ||
                      (op == OP_NX_OFF) || (op == OP_NX_ON);
    endfunction

    // Jump span: selectors 0..2 map to 1, 2, 4; selectors 3..6 map to 16..128.
    function automatic cmd_byte_t jump_span(input logic [2:0] sel);
        if (sel < 3'd3) jump_span = cmd_byte_t'(1) << sel;
        else            jump_span = cmd_byte_t'(1) << (sel + 3'd1);
    endfunction
endpackage

// File: rtl/svc_sync.sv
module svc_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/svc_clk_filter.sv
module svc_clk_filter #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= 1'b0;
            run_cnt <= '0;
        end else if (!en) begin
            dout    <= din;
            run_cnt <= '0;
        end else if (din == dout) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_LAST) begin
            dout    <= din;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (dout != $past(dout))) |->
            (($past(din) == dout) && ($past(din, 2) == dout))); // R9
endmodule

// File: rtl/svc_cmd_decode.sv
module svc_cmd_decode
    import svc_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic [CNT_W-1:0]   bit_cnt,
    input  logic [2*CMD_W-1:0] shreg,
    output logic               ok,
    output cmd_byte_t          op,
    output cmd_byte_t          arg
);
    always_comb begin
        ok  = 1'b0;
        op  = '0;
        arg = '0;
        if (bit_cnt == CNT_W'(CMD_W)) begin
            op = shreg[CMD_W-1:0];
            ok = is_one_byte(op);
        end else if (bit_cnt == CNT_W'(2 * CMD_W)) begin
            op  = shreg[2*CMD_W-1:CMD_W];
            arg = shreg[CMD_W-1:0];
            ok  = (op == OP_TCOUNT);
        end
    end
endmodule

// File: rtl/svc_cmd_rx.sv
module svc_cmd_rx
    import svc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             strobe,
    input  logic             sdata,
    input  logic             sclk,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_opcode,
    output logic [CMD_W-1:0] cmd_operand,
    output logic             focus_on,
    output logic [CMD_W-1:0] jump_tracks,
    output logic             motor_run,
    output logic             mute_on,
    output logic [CMD_W-1:0] track_count,
    output logic [1:0]       gp_out,
    output logic             deglitch_on
);
    localparam int unsigned FRAME_BITS = 2 * CMD_W;
    localparam int unsigned CNT_MAX    = FRAME_BITS + 1;
    localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);
    localparam int unsigned IN_W       = 4;

    logic s_cs_n, s_strobe, s_data, s_sclk;
    logic f_sclk;
    logic strobe_d, sclk_d;
    logic strobe_rise, strobe_fall, sclk_rise;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  dec_ok;
    cmd_byte_t             dec_op, dec_arg;
    rx_state_t             state, nstate;

    svc_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, strobe, sdata, sclk}),
        .q     ({s_cs_n, s_strobe, s_data, s_sclk})
    );

    svc_clk_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (deglitch_on),
        .din   (s_sclk),
        .dout  (f_sclk)
    );

    svc_cmd_decode #(.CNT_W(CNT_W)) u_dec (
        .bit_cnt (bit_cnt),
        .shreg   (shreg),
        .ok      (dec_ok),
        .op      (dec_op),
        .arg     (dec_arg)
    );

    assign strobe_rise = s_strobe & ~strobe_d;
    assign strobe_fall = ~s_strobe & strobe_d;
    assign sclk_rise   = f_sclk & ~sclk_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Transitions: open (IDLE->RECV), close (RECV->EXEC), done (EXEC->IDLE)
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (strobe_rise) nstate = ST_RECV;
            ST_RECV: if (strobe_fall) nstate = ST_EXEC;
            ST_EXEC: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // Datapath and command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_d    <= 1'b0;
            sclk_d      <= 1'b0;
            bit_cnt     <= '0;
            shreg       <= '0;
            cmd_valid   <= 1'b0;
            cmd_opcode  <= '0;
            cmd_operand <= '0;
            focus_on    <= 1'b0;
            jump_tracks <= '0;
            motor_run   <= 1'b0;
            mute_on     <= 1'b0;
            track_count <= '0;
            gp_out      <= '0;
            deglitch_on <= 1'b0;
        end else begin
            strobe_d  <= s_strobe;
            sclk_d    <= f_sclk;
            cmd_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (strobe_rise) begin
                        bit_cnt <= '0;
                        shreg   <= '0;
                    end
                end
                ST_RECV: begin
                    if (sclk_rise && !s_cs_n) begin
                        shreg <= {shreg[FRAME_BITS-2:0], s_data};
                        if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_EXEC: begin
                    if (dec_ok && !s_cs_n) begin
                        cmd_valid   <= 1'b1;
                        cmd_opcode  <= dec_op;
                        cmd_operand <= dec_arg;
                        case (dec_op) inside
                            OP_FOCUS_OFF, OP_FOCUS_ON:     focus_on    <= dec_op[0];
                            OP_MOTOR_STOP, OP_MOTOR_RUN:   motor_run   <= dec_op[0];
                            OP_MUTE_OFF, OP_MUTE_ON:       mute_on     <= dec_op[0];
                            [OP_JUMP_BASE:OP_JUMP_LAST]:   jump_tracks <= jump_span(dec_op[2:0]);
                            [OP_GP_BASE:OP_GP_LAST]:       gp_out      <= dec_op[1:0];
                            OP_TCOUNT:                     track_count <= dec_arg;
                            OP_NX_OFF, OP_NX_ON:           deglitch_on <= dec_op[0];
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R10

    AST_EXEC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |-> ($past(state) == ST_RECV) && $past(strobe_fall)); // R2

    AST_REGS_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({focus_on, jump_tracks, motor_run, mute_on, track_count, gp_out, deglitch_on})
            |-> cmd_valid); // R6

    AST_TCOUNT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_opcode == OP_TCOUNT)) |-> ($past(bit_cnt) == CNT_W'(FRAME_BITS))); // R5

    AST_DESELECT_NO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RECV) && s_cs_n) |=> $stable(bit_cnt)); // R7
endmodule

// File: tb/svc_cmd_rx_test.sv
module svc_cmd_rx_test;
    localparam int LAT = 4; // two synchronizer stages + fall detect + execute

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, cs_n = 1'b1, strobe = 1'b0, sdata = 1'b0, sclk = 1'b0;
    logic       cmd_valid, focus_on, motor_run, mute_on, deglitch_on;
    logic [7:0] cmd_opcode, cmd_operand, jump_tracks, track_count;
    logic [1:0] gp_out;

    svc_cmd_rx uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strobe(strobe), .sdata(sdata), .sclk(sclk),
        .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_operand(cmd_operand),
        .focus_on(focus_on), .jump_tracks(jump_tracks), .motor_run(motor_run),
        .mute_on(mute_on), .track_count(track_count), .gp_out(gp_out), .deglitch_on(deglitch_on)
    );

    int    cyc = 0;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    string tag = "R11";

    bit       e_valid, e_focus, e_motor, e_mute, e_dg;
    bit [7:0] e_op, e_arg, e_jump, e_tcnt;
    bit [1:0] e_gp;
    bit       pend;
    int       pend_cyc;
    bit [7:0] p_op, p_arg;
    bit       acc[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string fld, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s/%s %s: actual %0d expected %0d at cycle %0d", req, tag, fld, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        e_valid = 0; e_focus = 0; e_motor = 0; e_mute = 0; e_dg = 0;
        e_op = 0; e_arg = 0; e_jump = 0; e_tcnt = 0; e_gp = 0; pend = 0;
    endtask

    function automatic bit one_byte_op(input bit [7:0] op);
        return op inside {8'h10, 8'h11, [8'h20:8'h26], 8'h30, 8'h31, 8'h40, 8'h41,
                          [8'h50:8'h53], 8'hEE, 8'hEF};
    endfunction

    task automatic model_apply(input bit [7:0] op, input bit [7:0] arg);
        int spans[7] = '{1, 2, 4, 16, 32, 64, 128};
        e_op = op; e_arg = arg;
        if (op == 8'h10) e_focus = 0;
        if (op == 8'h11) e_focus = 1;
        if (op >= 8'h20 && op <= 8'h26) e_jump = 8'(spans[op - 8'h20]);
        if (op == 8'h30) e_motor = 0;
        if (op == 8'h31) e_motor = 1;
        if (op == 8'h40) e_mute = 0;
        if (op == 8'h41) e_mute = 1;
        if (op >= 8'h50 && op <= 8'h53) e_gp = op[1:0];
        if (op == 8'h60) e_tcnt = arg;
        if (op == 8'hEE) e_dg = 0;
        if (op == 8'hEF) e_dg = 1;
    endtask

    // Compare the design against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            e_valid = 0;
            if (pend && cyc == pend_cyc) begin
                pend = 0;
                e_valid = 1;
                model_apply(p_op, p_arg);
            end
            chk("R10", "cmd_valid", int'(cmd_valid), int'(e_valid));
            if (e_valid) begin
                chk("R10", "cmd_opcode", int'(cmd_opcode), int'(e_op));
                chk("R5", "cmd_operand", int'(cmd_operand), int'(e_arg));
            end
            chk("R3", "focus_on", int'(focus_on), int'(e_focus));
            chk("R3", "motor_run", int'(motor_run), int'(e_motor));
            chk("R3", "mute_on", int'(mute_on), int'(e_mute));
            chk("R3", "gp_out", int'(gp_out), int'(e_gp));
            chk("R4", "jump_tracks", int'(jump_tracks), int'(e_jump));
            chk("R5", "track_count", int'(track_count), int'(e_tcnt));
            chk("R8", "deglitch_on", int'(deglitch_on), int'(e_dg));
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        sdata = b;
        wait_clk(6);
        sclk = 1;
        if (!cs_n) acc.push_back(b);
        wait_clk(6);
        sclk = 0;
    endtask

    // One-system-clock pulse on the serial clock (R9).
    task automatic glitch();
        sdata = 1;
        wait_clk(6);
        sclk = 1;
        wait_clk(1);
        sclk = 0;
        if (!cs_n && !e_dg) acc.push_back(1'b1);
        wait_clk(6);
    endtask

    task automatic frame(input bit [15:0] word, input int nbits, input int glitch_at = -1,
                         input int skip_lo = -1, input int skip_hi = -1, input bit sel = 1);
        int n;
        bit [7:0] o, a;
        bit ok;
        acc.delete();
        cs_n = !sel;
        wait_clk(4);
        strobe = 1;
        wait_clk(6);
        for (int i = 0; i < nbits; i++) begin
            if (i == glitch_at) glitch();
            cs_n = (i >= skip_lo && i < skip_hi) ? 1'b1 : !sel;
            send_bit(word[nbits-1-i]);
        end
        cs_n = !sel;
        wait_clk(6);
        strobe = 0;
        n = acc.size(); o = 0; a = 0; ok = 0;
        if (!cs_n) begin
            if (n == 8) begin
                for (int i = 0; i < 8; i++) o = {o[6:0], acc[i]};
                ok = one_byte_op(o);
            end else if (n == 16) begin
                for (int i = 0; i < 8; i++) o = {o[6:0], acc[i]};
                for (int i = 8; i < 16; i++) a = {a[6:0], acc[i]};
                ok = (o == 8'h60);
            end
        end
        if (ok) begin
            pend = 1; pend_cyc = cyc + LAT; p_op = o; p_arg = a;
        end
        wait_clk(12);
        cs_n = 0;
    endtask

    task automatic cmd1(input bit [7:0] op);
        frame({8'h00, op}, 8);
    endtask

    task automatic do_reset();
        rst_n = 0;
        wait_clk(3);
        model_reset();
        rst_n = 1;
        wait_clk(3);
    endtask

    initial begin
        model_reset();
        wait_clk(5);
        rst_n = 1;
        tag = "R11";                       // reset state compared on every clock
        wait_clk(10);
        cs_n = 0;

        tag = "R3";                        // single-byte controls, executed on strobe fall (R2)
        cmd1(8'h41); cmd1(8'h11); cmd1(8'h31); cmd1(8'h52); cmd1(8'h53);
        cmd1(8'h40); cmd1(8'h10); cmd1(8'h50);

        tag = "R4";                        // every jump span
        for (int k = 0; k < 7; k++) cmd1(8'(8'h20 + k));

        tag = "R1";                        // MSB-first order seen through the count byte
        frame(16'h6001, 16); frame(16'h6080, 16);
        tag = "R5";
        frame(16'h60A5, 16);

        tag = "R6";                        // discarded frames
        cmd1(8'h27);
        frame(16'h0060, 8);
        frame(16'h4100, 16);
        frame(16'h0413, 12);
        frame(16'h0031, 8, -1, -1, -1, 0); // select high at the fall

        tag = "R7";                        // second byte sent with select high is ignored
        frame(16'h41FF, 16, -1, 8, 16, 1);
        cmd1(8'h40);
        frame(16'h6077, 16, -1, 0, 4, 1);  // first four bits ignored -> 12 bits, dropped

        tag = "R9";                        // filter off: glitch adds a bit -> dropped
        frame(16'h0041, 8, 3);
        tag = "R8";
        cmd1(8'hEF);
        tag = "R9";                        // filter on: glitches are absorbed
        frame(16'h0041, 8, 3);
        frame(16'h6033, 16, 5);
        tag = "R8";
        cmd1(8'hEE);
        frame(16'h0040, 8, 2);             // filter off again -> dropped
        cmd1(8'hEF);
        do_reset();                        // reset clears the filter (R11 state checked too)
        cs_n = 0;
        frame(16'h0041, 8, 4);             // dropped because the filter is off
        cmd1(8'h41);
        tag = "R2";
        cmd1(8'h31);

        wait_clk(10);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog %s: actual timeout expected completion", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule